// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures how long a chosen low-frequency clock takes to complete a programmed number of its own cycles, counted in cycles of a fast reference clock. Up to four slow sources come in as plain asynchronous signals. Each one passes through its own synchroniser in the reference domain, and a select picks which one is measured. Software sets the window length in slow cycles and a timeout threshold in reference cycles. It then raises the start bit, or turns on continuous-cycling mode, and waits for either the ready flag or the timeout flag.

The result is a raw reference-cycle count. Turning it into a frequency or a fixed-point period is left to software. A usual threshold setting is the window length shifted left by 12 for the crystal and divided-oscillator sources, and shifted left by 10 for the mux source. If a run ends in a timeout, software treats the result as zero, and the block also forces the result to zero in that case. Before a one-shot start, software drops the cycling mode and waits for the run in flight to end.

Top module: `slowclk_cal`

## Requirements
- R1: After reset, `ready`, `timeout` and `result` are all zero.
- R2: `src_sel` picks the measured input `slow_clk_in[src_sel]`. The encoding is 0 for the slow-clock mux output, 1 for the 8 MHz oscillator divided by 256, 2 for the 32 kHz crystal and 3 for the internal oscillator. A select value with no source behind it measures a constant low input.
- R3: A rising edge on `start` while the block is idle arms a run. The window opens on the first synchronised rising edge of the selected source after arming. It closes on the `win_cycles`-th rising edge after that one, and a window of 0 is treated as 1. The count equals `win_cycles` times the slow period in reference cycles.
- R4: When a window closes, `ready` goes high and `result` takes the count. `result` changes only at a completion or a timeout, and it is held in between.
- R5: The count runs from arming until the window opens, and then again from the window start. If the count would exceed `tmo_thresh` before the window closes, `timeout` goes high, `ready` goes low, `result` becomes 0 and the block goes idle. If the window closes in the same cycle, the completion takes priority.
- R6: The count saturates at its maximum value (all ones over `CNT_W` bits) and does not wrap.
- R7: A falling edge on `start` aborts any run, clears `ready` and `timeout` and returns the block to idle. No completion follows an abort.
- R8: A rising edge on `cycling` while idle arms a run. While `cycling` is high, each completion re-arms the block for a new window and updates `result`, and `ready` stays high.
- R9: Once `cycling` is lowered, the window in flight finishes normally and the block then stays idle, so `result` stops updating.
- R10: `ready` and `timeout` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_in | input | NUM_SRC | Asynchronous slow clock sources |
| src_sel | input | SEL_W | Index of the source to measure |
| win_cycles | input | WIN_W | Window length in slow-clock cycles |
| start | input | 1 | One-shot launch on rise, abort on fall |
| cycling | input | 1 | Continuous-cycling mode |
| tmo_thresh | input | TMO_W | Timeout threshold in reference cycles |
| result | output | CNT_W | Held measurement result |
| ready | output | 1 | Measurement complete |
| timeout | output | 1 | Measurement timed out |

## Verification
The closing of a window and the timeout decision can fall in the same reference cycle. This happens when the threshold is exactly one below the window length in reference cycles. The bench provokes this with a slow clock of exact, known period. It expects completion to win in that case, with `ready` high and the full count in the result. With the threshold lowered by one more, it expects `timeout` with a zero result instead. A scoreboard pairs every rise of `ready` or `timeout` with an expectation queued by the driver, and checks the flag kind, the result and that the two flags are never high together.

// File: rtl/slowclk_cal_pkg.sv
package slowclk_cal_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE    = 2'd0,
    CAL_ARMED   = 2'd1,
    CAL_MEASURE = 2'd2
  } cal_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/slowclk_cal_sync.sv
module slowclk_cal_sync #(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] slow_in,
  input  logic [SEL_W-1:0]   sel,
  output logic               rise_o
);

  localparam int PAD_N = 2 ** SEL_W;
  localparam int LAST  = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] synced;
  logic [PAD_N-1:0]   padded;
  logic               picked;
  logic               picked_q;

  // one synchroniser chain per source, selection happens after sync
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= (chain << 1) | SYNC_STAGES'(slow_in[g]);
    end
    assign synced[g] = chain[LAST];
  end

  assign padded = PAD_N'(synced);
  assign picked = padded[sel];

  always_ff @(posedge clk) begin
    if (rst) picked_q <= 1'b0;
    else     picked_q <= picked;
  end

  assign rise_o = picked & ~picked_q;

endmodule

// File: rtl/slowclk_cal_count.sv
module slowclk_cal_count #(
  parameter int WIN_W = 16,
  parameter int CNT_W = 20,
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero,
  input  logic             counting,
  input  logic             in_run,
  input  logic             edge_i,
  input  logic [WIN_W-1:0] win,
  input  logic [TMO_W-1:0] thresh,
  input  logic             cap_done,
  input  logic             cap_tmo,
  output logic             win_end,
  output logic             over,
  output logic [CNT_W-1:0] result,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int CMP_W = slowclk_cal_pkg::max_int(CNT_W, TMO_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [WIN_W-1:0] seen_q;
  logic [WIN_W:0]   seen_next;

  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
  assign over      = CMP_W'(cnt_inc) > CMP_W'(thresh);
  assign seen_next = {1'b0, seen_q} + (WIN_W + 1)'(1);
  assign win_end   = edge_i && (seen_next >= {1'b0, win});
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      seen_q <= '0;
    end else if (zero) begin
      cnt_q  <= '0;
      seen_q <= '0;
    end else if (counting) begin
      cnt_q <= cnt_inc;
      if (in_run && edge_i) seen_q <= seen_next[WIN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           result <= '0;
    else if (cap_done) result <= cnt_inc;
    else if (cap_tmo)  result <= '0;
  end

endmodule

// File: rtl/slowclk_cal_ctrl.sv
module slowclk_cal_ctrl
  import slowclk_cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cycling,
  input  logic slow_rise,
  input  logic win_end,
  input  logic over,
  output logic zero,
  output logic counting,
  output logic in_run,
  output logic cap_done,
  output logic cap_tmo,
  output logic busy,
  output logic ready,
  output logic timeout
);

  cal_state_e state_q, state_d;
  logic start_q, cyc_q;
  logic start_rise, start_fall, cyc_rise;
  logic arm, wait_hit, done, tmo;

  assign start_rise = start & ~start_q;
  assign start_fall = ~start & start_q;
  assign cyc_rise   = cycling & ~cyc_q;

  assign arm      = (state_q == CAL_IDLE) && !start_fall && (start_rise || cyc_rise);
  assign wait_hit = (state_q == CAL_ARMED) && slow_rise && !start_fall;
  assign done     = (state_q == CAL_MEASURE) && win_end && !start_fall;
  assign tmo      = !start_fall && over &&
                    (((state_q == CAL_ARMED) && !slow_rise) ||
                     ((state_q == CAL_MEASURE) && !win_end));

  assign zero     = arm || wait_hit || (done && cycling);
  assign counting = (state_q != CAL_IDLE);
  assign in_run   = (state_q == CAL_MEASURE);
  assign cap_done = done;
  assign cap_tmo  = tmo;
  assign busy     = counting;

  always_comb begin
    state_d = state_q;
    if (start_fall) begin
      state_d = CAL_IDLE;
    end else begin
      unique case (state_q)
        CAL_IDLE:    if (arm) state_d = CAL_ARMED;
        CAL_ARMED: begin
          if (slow_rise) state_d = CAL_MEASURE;
          else if (tmo)  state_d = CAL_IDLE;
        end
        CAL_MEASURE: begin
          if (done)     state_d = cycling ? CAL_ARMED : CAL_IDLE;
          else if (tmo) state_d = CAL_IDLE;
        end
        default:     state_d = CAL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CAL_IDLE;
      start_q <= 1'b0;
      cyc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start;
      cyc_q   <= cycling;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start_fall || arm) begin
      ready   <= 1'b0;
      timeout <= 1'b0;
    end else if (done) begin
      ready <= 1'b1;
    end else if (tmo) begin
      ready   <= 1'b0;
      timeout <= 1'b1;
    end
  end

endmodule

// File: rtl/slowclk_cal.sv
module slowclk_cal #(
  parameter int NUM_SRC     = 4,
  parameter int SEL_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_W       = 16,
  parameter int CNT_W       = 20,
  parameter int TMO_W       = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] slow_clk_in,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [WIN_W-1:0]   win_cycles,
  input  logic               start,
  input  logic               cycling,
  input  logic [TMO_W-1:0]   tmo_thresh,
  output logic [CNT_W-1:0]   result,
  output logic               ready,
  output logic               timeout
);

  logic             rise_w;
  logic             zero_w, counting_w, in_run_w;
  logic             cap_done_w, cap_tmo_w, busy_w;
  logic             win_end_w, over_w;
  logic [CNT_W-1:0] cnt_w;

  slowclk_cal_sync #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES),
    .SEL_W      (SEL_W)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .slow_in(slow_clk_in),
    .sel    (src_sel),
    .rise_o (rise_w)
  );

  slowclk_cal_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cycling  (cycling),
    .slow_rise(rise_w),
    .win_end  (win_end_w),
    .over     (over_w),
    .zero     (zero_w),
    .counting (counting_w),
    .in_run   (in_run_w),
    .cap_done (cap_done_w),
    .cap_tmo  (cap_tmo_w),
    .busy     (busy_w),
    .ready    (ready),
    .timeout  (timeout)
  );

  slowclk_cal_count #(
    .WIN_W(WIN_W),
    .CNT_W(CNT_W),
    .TMO_W(TMO_W)
  ) u_count (
    .clk     (clk),
    .rst     (rst),
    .zero    (zero_w),
    .counting(counting_w),
    .in_run  (in_run_w),
    .edge_i  (rise_w),
    .win     (win_cycles),
    .thresh  (tmo_thresh),
    .cap_done(cap_done_w),
    .cap_tmo (cap_tmo_w),
    .win_end (win_end_w),
    .over    (over_w),
    .result  (result),
    .cnt_o   (cnt_w)
  );

endmodule

// File: rtl/slowclk_cal_chk.sv
module slowclk_cal_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             ready,
  input logic             timeout,
  input logic             busy,
  input logic             counting,
  input logic             zero,
  input logic [CNT_W-1:0] result,
  input logic [CNT_W-1:0] cnt
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ready && timeout)); // R10

  AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> (result == '0)); // R5

  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> !busy); // R5

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(start) |=> (!ready && !timeout)); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> (ready || timeout)); // R4

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (counting && !zero) |=> (cnt >= $past(cnt))); // R6

endmodule

bind slowclk_cal slowclk_cal_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .ready   (ready),
  .timeout (timeout),
  .busy    (busy_w),
  .counting(counting_w),
  .zero    (zero_w),
  .result  (result),
  .cnt     (cnt_w)
);

// File: tb/test_slowclk_cal.sv
module test_slowclk_cal;

  localparam int NS = 4;
  localparam int WW = 16;
  localparam int CW = 10;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NS-1:0] slow = '0;
  logic [1:0]    sel = '0;
  logic [WW-1:0] win = '0;
  logic          start = 1'b0;
  logic          cyc = 1'b0;
  logic [TW-1:0] thr = '0;
  logic [CW-1:0] result;
  logic          ready, tmo;

  int hp[NS] = '{default: 0};
  int ph[NS] = '{default: 0};
  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    bit    is_tmo;
    int    val;
    string tag;
  } exp_t;
  exp_t sb[$];
  exp_t cur;

  slowclk_cal #(
    .NUM_SRC(NS), .WIN_W(WW), .CNT_W(CW), .TMO_W(TW)
  ) i_slowclk_cal (
    .clk(clk), .rst(rst), .slow_clk_in(slow), .src_sel(sel),
    .win_cycles(win), .start(start), .cycling(cyc), .tmo_thresh(thr),
    .result(result), .ready(ready), .timeout(tmo)
  );

  // slow clocks of exact period 2*hp reference cycles; hp of 0 holds low
  always @(negedge clk) begin
    for (int i = 0; i < NS; i++) begin
      if (hp[i] == 0) begin
        slow[i] = 1'b0;
        ph[i] = 0;
      end else if (ph[i] + 1 >= hp[i]) begin
        ph[i] = 0;
        slow[i] = ~slow[i];
      end else begin
        ph[i] = ph[i] + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  // monitor: every new completion or timeout is compared with the queue head
  logic rdy_q = 1'b0, tmo_q = 1'b0;
  always @(negedge clk) begin
    if (!rst && ((ready && !rdy_q) || (tmo && !tmo_q))) begin
      if (sb.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R7: unexpected event, actual result %0d expected none", result);
      end else begin
        cur = sb.pop_front();
        chk({cur.tag, " kind"}, int'(tmo), int'(cur.is_tmo));
        chk({cur.tag, " result"}, int'(result), cur.val);
        chk("R10 flags exclusive", int'(ready && tmo), 0);
      end
    end
    rdy_q = ready;
    tmo_q = tmo;
  end

  task automatic wait_event(input int lim, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (ready || tmo) begin
        seen = 1'b1;
        break;
      end
    end
    if (!seen) chk({tag, " no event"}, 0, 1);
    @(negedge clk);
  endtask

  task automatic run_one(input int s, input int w, input int t,
                         input bit e_tmo, input int e_val, input string tag);
    start = 1'b0;
    @(negedge clk);
    sel = 2'(s);
    win = WW'(w);
    thr = TW'(t);
    repeat (4) @(negedge clk);
    sb.push_back('{e_tmo, e_val, tag});
    start = 1'b1;
    wait_event(5000, tag);
  endtask

  task automatic finish_run();
    chk("queue drained", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", int'(ready), 0);
    chk("R1 timeout", int'(tmo), 0);
    chk("R1 result", int'(result), 0);

    hp[0] = 5; hp[1] = 3; hp[2] = 7; hp[3] = 4;
    repeat (20) @(negedge clk);

    run_one(0, 4, 1000, 1'b0, 40, "R3 src0 window 4");
    run_one(2, 3, 1000, 1'b0, 42, "R2 src2 crystal");
    run_one(1, 1, 1000, 1'b0, 6,  "R2 src1 divided osc");
    run_one(1, 0, 1000, 1'b0, 6,  "R3 window 0 as 1");
    run_one(3, 5, 1000, 1'b0, 40, "R2 src3 internal osc");

    // R4: held result is unaffected by a changed source period
    hp[3] = 9;
    repeat (100) @(negedge clk);
    chk("R4 result held", int'(result), 40);
    chk("R4 ready held", int'(ready), 1);
    hp[3] = 4;

    // R5: completion and timeout in the same cycle, then one cycle earlier
    run_one(0, 4, 39, 1'b0, 40, "R5 tie completion wins");
    run_one(0, 4, 38, 1'b1, 0,  "R5 timeout before end");
    chk("R5 ready low on timeout", int'(ready), 0);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 abort clears timeout", int'(tmo), 0);

    // R5: dead slow clock
    hp[0] = 0;
    repeat (3) @(negedge clk);
    run_one(0, 2, 20, 1'b1, 0, "R5 dead clock");
    hp[0] = 5;

    // R6: saturation with a 1200-cycle window and 10-bit count
    hp[3] = 50;
    run_one(3, 12, 65535, 1'b0, 1023, "R6 saturation");
    hp[3] = 4;

    // R7: abort mid run, nothing completes afterwards
    start = 1'b0;
    @(negedge clk);
    sel = 2'd0; win = WW'(50); thr = TW'(60000);
    repeat (4) @(negedge clk);
    start = 1'b1;
    repeat (100) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 ready after abort", int'(ready), 0);
    chk("R7 timeout after abort", int'(tmo), 0);
    repeat (600) @(negedge clk);
    chk("R7 no late completion", int'(ready), 0);

    // R8: continuous cycling re-measures after a period change
    win = WW'(2);
    repeat (4) @(negedge clk);
    sb.push_back('{1'b0, 20, "R8 first cycling result"});
    cyc = 1'b1;
    wait_event(1000, "R8 cycling");
    hp[0] = 10;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (result == CW'(40)) break;
    end
    chk("R8 re-measured result", int'(result), 40);
    chk("R8 ready stays high", int'(ready), 1);

    // R9: stop cycling, window in flight finishes, then no updates
    cyc = 1'b0;
    repeat (200) @(negedge clk);
    chk("R9 ready after stop", int'(ready), 1);
    chk("R9 result after stop", int'(result), 40);
    hp[0] = 3;
    repeat (200) @(negedge clk);
    chk("R9 no further update", int'(result), 40);

    finish_run();
  end

endmodule